// File: doc/BRIEF.md
# Opcode-Driven SPI Shift Sequencer

This block is a half-duplex SPI master engine that has no fixed transfer format. Software, or a neighbouring controller, pushes 14-bit command words into a small operation queue. The engine pops them one at a time and turns each one into a bus action. The actions are: raise or lower chip select, emit idle clock pulses, shift bytes out on one, two or four lanes, shift bytes in on one, two or four lanes, or shift out and then release every IO line so that a read can follow.

Outgoing bytes come from an external first-word-fall-through transmit FIFO. Incoming bytes go into an external receive FIFO. When either FIFO cannot keep up, the engine waits with the serial clock parked low. The queue reports empty only once the last popped command has finished on the bus, so its empty flag also serves as a done indication.

Top module: `spi_opseq`

## Requirements
- R1: A command word carries the opcode in bits 13:9 and a byte/pulse count (0 to 511) in bits 8:0. Commands execute in push order. `op_empty` is high only when the queue holds nothing and the last popped command has fully finished.
- R2: Opcode 0x00 drives `cs_n` high and opcode 0x01 drives it low, with no SCK activity. `cs_n` never changes while a bus command is in progress.
- R3: Opcodes 0x08, 0x09 and 0x0A send `count` bytes MSB first from the transmit FIFO on 1, 2 or 4 lanes. Single lane uses IO0. In dual mode IO1 carries the higher bit of each pair. In quad mode IO3..IO0 carry bits 7..4 and then 3..0. `io_oe` becomes 0001, 0011 or 1111 and stays so afterwards.
- R4: Opcodes 0x0C, 0x0E and 0x0F receive `count` bytes MSB first. Single lane samples IO1, dual samples IO1:IO0 (IO1 higher), and quad samples IO3..IO0. All output enables are off, and each byte is delivered with a one-cycle `rx_push`.
- R5: Opcodes 0x10 to 0x18 shift out like R3, with single lanes for 0x10–0x12, dual for 0x13–0x15 and quad for 0x16–0x18. After the last byte, `io_oe` becomes 0000.
- R6: Opcode 0x02 emits exactly `count` SCK pulses without touching the IO lines or either FIFO.
- R7: SPI mode 0 is used. SCK idles low and each SCK phase lasts `DIV_HALF` system clocks. Outputs change only at SCK falling edges, and inputs are sampled at SCK rising edges.
- R8: When a shift-out needs a byte and `tx_empty` is high, SCK stays low until data arrives. No byte is lost or repeated.
- R9: When a received byte is ready while `rx_full` is high, SCK stays low and the byte is pushed once `rx_full` drops.
- R10: Any other opcode is consumed with no bus activity and sets `op_error`, which only reset clears.
- R11: A shift or idle-clock command with count 0 has no effect on the bus, the FIFOs or `io_oe`.
- R12: The queue holds `QDEPTH` commands and raises `op_full` when it holds that many.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_push | input | 1 | Write `op_word` into the operation queue |
| op_word | input | 14 | Command: opcode 13:9, count 8:0 |
| op_full | output | 1 | Operation queue full |
| op_empty | output | 1 | Queue empty and engine finished |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO has no byte |
| tx_pop | output | 1 | Consume `tx_data` this cycle |
| rx_full | input | 1 | Receive FIFO cannot accept a byte |
| rx_push | output | 1 | `rx_data` is valid for the receive FIFO |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data driven onto IO3..IO0 |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Data sampled from IO3..IO0 |
| op_error | output | 1 | Sticky reserved-opcode flag |

## Verification
A command pushed on one clock is popped on the next. Chip-select and error effects are therefore visible two clocks after the push, and the SCK period is fixed at 2·DIV_HALF clocks after the first low phase. A received byte reaches `rx_push` on the same clock that ends the command, so the receive side sees it one clock after `op_empty` rises. The bench polls `op_empty` on falling clock edges and then waits two further falling edges before it compares captured or received bytes. For the stall cases it waits a fixed span well beyond one byte time and then checks that SCK is low and that the pulse count has stopped at one byte.

// File: rtl/opseq_pkg.sv
// Shared types and opcode decoding for the SPI opcode sequencer.
// Assumes 5-bit opcodes; lane codes index widths 1, 2 and 4.
package opseq_pkg;
    localparam int OPC_W = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_CLK, ST_OUT, ST_IN} state_t;
    typedef enum logic [1:0] {LANE_1 = 2'd0, LANE_2 = 2'd1, LANE_4 = 2'd2} lane_t;

    localparam logic [4:0] OP_CS_HI   = 5'h00;
    localparam logic [4:0] OP_CS_LO   = 5'h01;
    localparam logic [4:0] OP_IDLECLK = 5'h02;
    localparam logic [4:0] OP_OUT1    = 5'h08;
    localparam logic [4:0] OP_OUT2    = 5'h09;
    localparam logic [4:0] OP_OUT4    = 5'h0A;
    localparam logic [4:0] OP_IN1     = 5'h0C;
    localparam logic [4:0] OP_IN2     = 5'h0E;
    localparam logic [4:0] OP_IN4     = 5'h0F;
    localparam logic [4:0] OP_TURN_LO = 5'h10;
    localparam logic [4:0] OP_TURN_HI = 5'h18;

    // True for plain and turnaround shift-out opcodes
    function automatic logic is_out(logic [4:0] op);
        return (op >= OP_OUT1 && op <= OP_OUT4) || (op >= OP_TURN_LO && op <= OP_TURN_HI);
    endfunction

    // True for shift-in opcodes
    function automatic logic is_in(logic [4:0] op);
        return op == OP_IN1 || op == OP_IN2 || op == OP_IN4;
    endfunction

    // Lane width used by a shift-out opcode
    function automatic lane_t out_lane(logic [4:0] op);
        if (op == OP_OUT1 || (op >= 5'h10 && op <= 5'h12)) return LANE_1;
        if (op == OP_OUT2 || (op >= 5'h13 && op <= 5'h15)) return LANE_2;
        return LANE_4;
    endfunction

    // Lane width used by a shift-in opcode
    function automatic lane_t in_lane(logic [4:0] op);
        if (op == OP_IN1) return LANE_1;
        if (op == OP_IN2) return LANE_2;
        return LANE_4;
    endfunction

    // Output-enable pattern for a lane width
    function automatic logic [3:0] lane_mask(lane_t l);
        case (l)
            LANE_1:  return 4'b0001;
            LANE_2:  return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Bits moved per SCK beat
    function automatic logic [3:0] lane_step(lane_t l);
        case (l)
            LANE_1:  return 4'd1;
            LANE_2:  return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

    // Index of the final beat inside one byte
    function automatic logic [2:0] last_beat(lane_t l);
        case (l)
            LANE_1:  return 3'd7;
            LANE_2:  return 3'd3;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/opseq_fifo.sv
// Small first-word-fall-through queue for command words.
// Assumes pushes while full and pops while empty are simply dropped.
module opseq_fifo #(
    parameter int WIDTH = 14,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CNTW-1:0]  cnt;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNTW'(DEPTH));
    assign rdata = mem[rp];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    a_r12_full_from_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(pop));
endmodule

// File: rtl/opseq_sck_gen.sv
// SCK generator: while run is high, toggles sck every DIV_HALF clocks
// starting from a low phase; reports the clock on which each edge occurs.
// Assumes the controller drops run only on a falling event or while sck is low.
module opseq_sck_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    wire edge_now = run && (cnt == LAST);

    assign rise_evt = edge_now && !sck;
    assign fall_evt = edge_now && sck;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/spi_opseq.sv
// Half-duplex SPI master that executes queued micro-op commands.
// Assumes a first-word-fall-through transmit FIFO (tx_data valid while
// !tx_empty) and a receive FIFO that accepts rx_push while !rx_full.
module spi_opseq
    import opseq_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int QDEPTH   = 4,
    parameter int CNT_W    = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_push,
    input  logic [13:0] op_word,
    output logic        op_full,
    output logic        op_empty,
    input  logic [7:0]  tx_data,
    input  logic        tx_empty,
    output logic        tx_pop,
    input  logic        rx_full,
    output logic        rx_push,
    output logic [7:0]  rx_data,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in,
    output logic        op_error
);
    localparam int WORD_W = OPC_W + CNT_W;

    logic              q_pop, q_empty;
    logic [WORD_W-1:0] q_head;
    logic              run, rise_evt, fall_evt;

    opseq_fifo #(.WIDTH(WORD_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(op_push), .wdata(op_word),
        .pop(q_pop), .rdata(q_head), .empty(q_empty), .full(op_full)
    );

    opseq_sck_gen #(.DIV_HALF(DIV_HALF)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(run), .sck(sck),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    state_t            state;
    lane_t             lw;
    logic              turn, loaded, pend;
    logic [CNT_W-1:0]  left;
    logic [2:0]        bcnt;
    logic [7:0]        sreg;

    wire [OPC_W-1:0] hd_op  = q_head[WORD_W-1 -: OPC_W];
    wire [CNT_W-1:0] hd_cnt = q_head[CNT_W-1:0];
    wire last_unit = (left == CNT_W'(1));
    wire byte_end  = fall_evt && (bcnt == 3'd0);

    assign q_pop    = (state == ST_IDLE) && !q_empty;
    assign op_empty = q_empty && (state == ST_IDLE);
    assign tx_pop   = (state == ST_OUT) && !tx_empty && (!loaded || (byte_end && !last_unit));

    // Lane mapping of the shift register onto the IO lines
    always_comb begin
        case (lw)
            LANE_1:  io_out = {3'b000, sreg[7]};
            LANE_2:  io_out = {2'b00, sreg[7:6]};
            default: io_out = sreg[7:4];
        endcase
    end

    // Shift register contents after one input sample
    logic [7:0] sampled;
    always_comb begin
        case (lw)
            LANE_1:  sampled = {sreg[6:0], io_in[1]};
            LANE_2:  sampled = {sreg[5:0], io_in[1:0]};
            default: sampled = {sreg[3:0], io_in};
        endcase
    end

    // Command decode and per-command bus sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; run <= 1'b0; cs_n <= 1'b1; io_oe <= 4'b0000;
            op_error <= 1'b0; lw <= LANE_1; turn <= 1'b0; loaded <= 1'b0;
            pend <= 1'b0; left <= '0; bcnt <= '0; sreg <= '0;
            rx_push <= 1'b0; rx_data <= '0;
        end else begin
            rx_push <= 1'b0;
            case (state)
                ST_IDLE: if (!q_empty) begin
                    if (hd_op == OP_CS_HI) begin
                        cs_n <= 1'b1;
                    end else if (hd_op == OP_CS_LO) begin
                        cs_n <= 1'b0;
                    end else if (hd_op == OP_IDLECLK) begin
                        if (hd_cnt != '0) begin
                            left <= hd_cnt; run <= 1'b1; state <= ST_CLK;
                        end
                    end else if (is_out(hd_op)) begin
                        if (hd_cnt != '0) begin
                            lw <= out_lane(hd_op); turn <= (hd_op >= OP_TURN_LO);
                            io_oe <= lane_mask(out_lane(hd_op));
                            left <= hd_cnt; loaded <= 1'b0; state <= ST_OUT;
                        end
                    end else if (is_in(hd_op)) begin
                        if (hd_cnt != '0) begin
                            lw <= in_lane(hd_op); io_oe <= 4'b0000; left <= hd_cnt;
                            bcnt <= last_beat(in_lane(hd_op)); pend <= 1'b0;
                            run <= 1'b1; state <= ST_IN;
                        end
                    end else begin
                        op_error <= 1'b1;
                    end
                end
                ST_CLK: if (fall_evt) begin
                    left <= left - 1'b1;
                    if (last_unit) begin run <= 1'b0; state <= ST_IDLE; end
                end
                ST_OUT: begin
                    if (!loaded) begin
                        if (!tx_empty) begin
                            sreg <= tx_data; loaded <= 1'b1; run <= 1'b1; bcnt <= last_beat(lw);
                        end
                    end else if (fall_evt) begin
                        if (bcnt != 3'd0) begin
                            sreg <= sreg << lane_step(lw); bcnt <= bcnt - 1'b1;
                        end else begin
                            left <= left - 1'b1;
                            if (last_unit) begin
                                run <= 1'b0; loaded <= 1'b0; state <= ST_IDLE;
                                if (turn) io_oe <= 4'b0000;
                            end else if (!tx_empty) begin
                                sreg <= tx_data; bcnt <= last_beat(lw);
                            end else begin
                                run <= 1'b0; loaded <= 1'b0;
                            end
                        end
                    end
                end
                ST_IN: begin
                    if (pend) begin
                        if (!rx_full) begin
                            rx_push <= 1'b1; pend <= 1'b0; left <= left - 1'b1;
                            if (last_unit) state <= ST_IDLE;
                            else begin run <= 1'b1; bcnt <= last_beat(lw); end
                        end
                    end else begin
                        if (rise_evt) sreg <= sampled;
                        if (fall_evt) begin
                            if (bcnt != 3'd0) begin
                                bcnt <= bcnt - 1'b1;
                            end else if (!rx_full) begin
                                rx_push <= 1'b1; rx_data <= sreg; left <= left - 1'b1;
                                bcnt <= last_beat(lw);
                                if (last_unit) begin run <= 1'b0; state <= ST_IDLE; end
                            end else begin
                                rx_data <= sreg; pend <= 1'b1; run <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r2_cs_held_in_command: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cs_n));
    a_r4_lines_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN) |-> (io_oe == 4'b0000));
    a_r8_clock_parked_when_starved: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && !loaded) |-> !sck);
    a_r9_no_push_into_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(!rx_full));
    a_r9_single_push_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);
    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |=> op_error);
    a_r1_empty_means_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        op_empty |-> !sck);
endmodule

// File: tb/spi_opseq_test.sv
`timescale 1ns/1ps
module spi_opseq_test;
    localparam int HALF = 2;
    localparam int QD   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_push = 1'b0;
    logic [13:0] op_word = '0;
    logic op_full, op_empty, tx_pop, rx_push, sck, cs_n, op_error;
    logic [7:0] tx_data, rx_data;
    logic tx_empty;
    logic rx_full = 1'b0;
    logic [3:0] io_out, io_oe, io_in;

    always #4 clk = ~clk;

    spi_opseq #(.DIV_HALF(HALF), .QDEPTH(QD), .CNT_W(9)) uut (
        .clk(clk), .rst_n(rst_n), .op_push(op_push), .op_word(op_word),
        .op_full(op_full), .op_empty(op_empty), .tx_data(tx_data), .tx_empty(tx_empty),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .op_error(op_error)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] tx_mem [32];
    int tx_wr = 0, tx_rd = 0;
    logic [7:0] rx_mem [16];
    int rx_n = 0;
    logic [7:0] cap_mem [16];
    int cap_n = 0, cap_bits = 0, rises = 0, last_rise = 0, prev_rise = 0;
    logic [7:0] cap_sr = '0;
    logic cap_on = 1'b0;
    int mon_w = 1;
    logic [7:0] sl_mem [8];
    int sl_pos = 0;
    logic [7:0] sl_tmp;

    // Transmit FIFO model
    assign tx_empty = (tx_wr == tx_rd);
    assign tx_data  = tx_mem[tx_rd % 32];
    always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

    // Receive FIFO model
    always @(posedge clk) if (rx_push) begin rx_mem[rx_n % 16] <= rx_data; rx_n <= rx_n + 1; end

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Slave capture on SCK rising edges
    always @(posedge sck) begin
        rises = rises + 1;
        prev_rise = last_rise;
        last_rise = cyc;
        if (cap_on) begin
            case (mon_w)
                1: cap_sr = {cap_sr[6:0], io_out[0]};
                2: cap_sr = {cap_sr[5:0], io_out[1:0]};
                default: cap_sr = {cap_sr[3:0], io_out};
            endcase
            cap_bits = cap_bits + mon_w;
            if (cap_bits >= 8) begin cap_mem[cap_n % 16] = cap_sr; cap_n = cap_n + 1; cap_bits = 0; end
        end
    end

    // Slave drive: advance on SCK falling edges
    always @(negedge sck) sl_pos = sl_pos + mon_w;
    always_comb begin
        sl_tmp = (sl_pos / 8 < 8) ? (sl_mem[(sl_pos / 8) % 8] << (sl_pos % 8)) : 8'h00;
        case (mon_w)
            1: io_in = {2'b00, sl_tmp[7], 1'b0};
            2: io_in = {2'b00, sl_tmp[7:6]};
            default: io_in = sl_tmp[7:4];
        endcase
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [4:0] op, input logic [8:0] n);
        op_word = {op, n}; op_push = 1'b1;
        @(negedge clk); op_push = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!op_empty) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_put(input logic [7:0] b);
        tx_mem[tx_wr % 32] = b; tx_wr++;
    endtask

    task automatic t_reset();
        chk("R2 reset cs_n", cs_n, 1);
        chk("R7 reset sck", sck, 0);
        chk("R3 reset io_oe", io_oe, 0);
        chk("R1 reset op_empty", op_empty, 1);
        chk("R10 reset op_error", op_error, 0);
    endtask

    task automatic t_cs();
        int r0 = rises;
        push_cmd(5'h01, 9'd1); wait_done();
        chk("R2 cs low", cs_n, 0);
        chk("R2 no sck on cs op", rises - r0, 0);
    endtask

    task automatic t_write(input logic [4:0] op, input int w, input logic [3:0] oe,
                           input logic [7:0] b0, input logic [7:0] b1);
        int rd0 = tx_rd;
        cap_n = 0; cap_bits = 0; mon_w = w; cap_on = 1'b1;
        tx_put(b0); tx_put(b1);
        push_cmd(op, 9'd2); wait_done(); cap_on = 1'b0;
        chk("R3 byte0", cap_mem[0], b0);
        chk("R3 byte1", cap_mem[1], b1);
        chk("R3 bytes captured", cap_n, 2);
        chk("R3 tx popped", tx_rd - rd0, 2);
        chk("R3 oe pattern", io_oe, oe);
        chk("R7 sck period", last_rise - prev_rise, 2 * HALF);
        chk("R7 sck idle", sck, 0);
    endtask

    task automatic t_read(input logic [4:0] op, input int w, input logic [7:0] b0, input logic [7:0] b1);
        int n0 = rx_n;
        mon_w = w; sl_mem[0] = b0; sl_mem[1] = b1; sl_pos = 0;
        push_cmd(op, 9'd2); wait_done();
        chk("R4 rx count", rx_n - n0, 2);
        chk("R4 rx byte0", rx_mem[n0 % 16], b0);
        chk("R4 rx byte1", rx_mem[(n0 + 1) % 16], b1);
        chk("R4 oe released", io_oe, 0);
    endtask

    task automatic t_turn();
        int n0;
        cap_n = 0; cap_bits = 0; mon_w = 2; cap_on = 1'b1;
        tx_put(8'hB4);
        push_cmd(5'h13, 9'd1); wait_done(); cap_on = 1'b0;
        chk("R5 turnaround data", cap_mem[0], 8'hB4);
        chk("R5 oe off after turnaround", io_oe, 0);
        n0 = rx_n; mon_w = 4; sl_mem[0] = 8'h5E; sl_pos = 0;
        push_cmd(5'h0F, 9'd1); wait_done();
        chk("R5 read after turnaround", rx_mem[n0 % 16], 8'h5E);
    endtask

    task automatic t_dummy();
        int r0 = rises, rd0 = tx_rd, n0 = rx_n;
        logic [3:0] oe0 = io_oe;
        push_cmd(5'h02, 9'd5); wait_done();
        chk("R6 pulse count", rises - r0, 5);
        chk("R6 oe unchanged", io_oe, oe0);
        chk("R6 no tx pop", tx_rd - rd0, 0);
        chk("R6 no rx push", rx_n - n0, 0);
    endtask

    task automatic t_zero();
        int r0 = rises, rd0 = tx_rd;
        logic [3:0] oe0 = io_oe;
        tx_put(8'h77);
        push_cmd(5'h0A, 9'd0); wait_done();
        push_cmd(5'h02, 9'd0); wait_done();
        chk("R11 no pulses", rises - r0, 0);
        chk("R11 no pop", tx_rd - rd0, 0);
        chk("R11 oe unchanged", io_oe, oe0);
        chk("R11 no error", op_error, 0);
        tx_rd = tx_wr;
    endtask

    task automatic t_bad();
        int r0 = rises;
        push_cmd(5'h05, 9'd3); wait_done();
        chk("R10 error set", op_error, 1);
        chk("R10 no bus", rises - r0, 0);
        push_cmd(5'h00, 9'd1); wait_done();
        chk("R10 error stays", op_error, 1);
        chk("R2 cs high", cs_n, 1);
    endtask

    task automatic t_tx_stall();
        int r0 = rises, rd0 = tx_rd;
        cap_n = 0; cap_bits = 0; mon_w = 1; cap_on = 1'b1;
        tx_put(8'hE7);
        push_cmd(5'h08, 9'd2);
        repeat (60) @(negedge clk);
        chk("R8 stalled one byte", rises - r0, 8);
        chk("R8 sck parked low", sck, 0);
        chk("R8 not done", op_empty, 0);
        tx_put(8'h18);
        wait_done(); cap_on = 1'b0;
        chk("R8 byte0", cap_mem[0], 8'hE7);
        chk("R8 byte1", cap_mem[1], 8'h18);
        chk("R8 pops", tx_rd - rd0, 2);
    endtask

    task automatic t_rx_stall();
        int r0 = rises, n0 = rx_n;
        mon_w = 1; sl_mem[0] = 8'h81; sl_mem[1] = 8'h42; sl_pos = 0;
        rx_full = 1'b1;
        push_cmd(5'h0C, 9'd2);
        repeat (60) @(negedge clk);
        chk("R9 nothing pushed", rx_n - n0, 0);
        chk("R9 one byte clocked", rises - r0, 8);
        chk("R9 sck parked low", sck, 0);
        rx_full = 1'b0;
        wait_done();
        chk("R9 byte0", rx_mem[n0 % 16], 8'h81);
        chk("R9 byte1", rx_mem[(n0 + 1) % 16], 8'h42);
    endtask

    task automatic t_queue();
        op_word = {5'h02, 9'd40}; op_push = 1'b1; @(negedge clk);
        op_word = {5'h00, 9'd1}; @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        op_word = {5'h01, 9'd1}; @(negedge clk);
        op_push = 1'b0;
        chk("R12 queue full", op_full, 1);
        chk("R1 busy while queued", op_empty, 0);
        wait_done();
        chk("R12 drained", op_full, 0);
        chk("R1 last command last", cs_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cs();
        t_write(5'h08, 1, 4'b0001, 8'hA5, 8'h3C);
        t_write(5'h09, 2, 4'b0011, 8'h96, 8'h5A);
        t_write(5'h0A, 4, 4'b1111, 8'h12, 8'h34);
        t_dummy();
        t_zero();
        t_read(5'h0C, 1, 8'hC3, 8'h7E);
        t_read(5'h0E, 2, 8'h69, 8'hD2);
        t_read(5'h0F, 4, 8'hAB, 8'h0F);
        t_turn();
        t_bad();
        t_tx_stall();
        t_rx_stall();
        t_queue();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule